// File: doc/BRIEF.md
# Address Table with Slot Search

This block holds the address table of an Ethernet switch. Each entry is 68 bits wide. Software reaches the table only through an indirect window. It writes a table-control register that names an entry index and either loads that entry into three 32-bit data words or stores the data words into the entry. The entry's bits are spread over the words in reversed order: the first word carries the top four bits and the last word carries bits 31:0.

Before software adds an address, it starts a hardware search with the MAC it wants to place. The engine reads one entry per clock and returns the slot to use:
- an address entry that already holds that MAC, if there is one;
- otherwise the lowest free entry;
- otherwise the lowest unicast entry that may be aged out.

If none of these exists, the search reports that nothing was found.

A control register holds an enable bit and a VLAN-aware bit. It also starts a self-timed clear that walks every entry back to the free type. Each port has a two-bit forwarding-state register.

Top module: `addr_lookup_table`

## Requirements
- R1: After reset the control register (offset 0x08) reads 0, every port-state register reads 0, and the search is neither busy nor done.
- R2: A write to the table-control register (offset 0x20) with bit 31 set stores the data words into the entry whose index is in the low bits. The word at 0x34 holds entry bits 67:64 in its bits 3:0, the word at 0x38 holds bits 63:32, and the word at 0x3C holds bits 31:0.
- R3: A write to the table-control register with bit 31 clear loads the indexed entry into the three data words, using the same layout, one cycle later.
- R4: Control bit 31 (enable) and bit 2 (VLAN-aware) are stored and read back.
- R5: Writing control bit 30 sets every entry to all zeros, which is entry type 0 (free), at one entry per cycle. Bit 30 reads 1 until the last entry has been written, then reads 0.
- R6: A search returns found=1 and the index of an entry whose type field (bits 61:60) is 1 or 3 and whose bits 47:0 equal the searched MAC. This result takes priority over any free or ageable entry, including ones at lower indices.
- R7: With no matching entry, a search returns the lowest index whose type field is 0.
- R8: With no match and no free entry, a search returns the lowest entry of type 1 or 3 with bit 40 clear (unicast) and unicast type (bits 63:62) equal to 1 or 3.
- R9: With no match, no free entry and no ageable entry, a search ends with found=0.
- R10: A search keeps busy high for one cycle per entry examined, ends with a one-cycle done pulse, and ignores start while it is busy.
- R11: Port p has a state register at offset 0x40+4p that keeps the two low bits written to it and reads 0 in bits 31:2.
- R12: Entries of type 2, multicast entries (bit 40 set), and unicast entries of type 0 or 2 are never returned as a match or as ageable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | AW | Register read byte offset |
| rd_data | output | 32 | Register read data (combinational) |
| srch_start | input | 1 | Start a slot search |
| srch_mac | input | 48 | MAC address to place |
| srch_busy | output | 1 | Search in progress |
| srch_done | output | 1 | One-cycle pulse at search end |
| srch_found | output | 1 | A slot was found |
| srch_idx | output | IW | Index of the slot found |

## Verification
The bench targets priority inversions.
- A matching entry placed behind a free slot must win. A design that stopped at the first free slot would return index 2 instead of 9.
- A VLAN-type entry carries the searched MAC and has touched bits set. A design that decoded the type field loosely would match it or age it.
- Multicast, OUI and persistent entries sit ahead of the first ageable one. They expose an ageable test that ignores the multicast bit or the unicast type.
- A second start is pulsed mid-search, and the busy length of each search is counted. This catches a design that restarts or stops scanning early.
- Reading back a known pattern exposes a design that gets the word order of the window wrong.

// File: rtl/addr_lookup_table.sv
module addr_lookup_table #(
  parameter int DEPTH  = 64,
  parameter int NPORTS = 3,
  parameter int AW     = 8,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  input  logic          srch_start,
  input  logic [47:0]   srch_mac,
  output logic          srch_busy,
  output logic          srch_done,
  output logic          srch_found,
  output logic [IW-1:0] srch_idx
);
  localparam logic [AW-1:0] OFS_CTRL = AW'(8'h08);
  localparam logic [AW-1:0] OFS_TCTL = AW'(8'h20);
  localparam logic [AW-1:0] OFS_DW0  = AW'(8'h34);
  localparam logic [AW-1:0] OFS_DW1  = AW'(8'h38);
  localparam logic [AW-1:0] OFS_DW2  = AW'(8'h3C);
  localparam int            OFS_PORT = 'h40;

  logic [67:0]   tbl [DEPTH];
  logic [3:0]    dw0;
  logic [31:0]   dw1, dw2;
  logic [IW-1:0] tidx;
  logic          en_q, vlan_q, clr_q;
  logic [IW-1:0] clr_cnt;
  logic [1:0]    pst [NPORTS];

  wire wr_ctrl = wr_en && wr_addr == OFS_CTRL;
  wire wr_tctl = wr_en && wr_addr == OFS_TCTL;
  wire tbl_wr  = wr_tctl && wr_data[31] && !clr_q;
  wire tbl_ld  = wr_tctl && !wr_data[31];
  wire [IW-1:0] widx = wr_data[IW-1:0];

  // table storage: clear walk has priority over software writes
  always_ff @(posedge clk) begin
    if (clr_q) tbl[clr_cnt] <= '0;
    else if (tbl_wr) tbl[widx] <= {dw0, dw1, dw2};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dw0 <= '0; dw1 <= '0; dw2 <= '0; tidx <= '0;
    end else begin
      if (wr_tctl) tidx <= widx;
      if (tbl_ld) begin
        dw0 <= tbl[widx][67:64];
        dw1 <= tbl[widx][63:32];
        dw2 <= tbl[widx][31:0];
      end else begin
        if (wr_en && wr_addr == OFS_DW0) dw0 <= wr_data[3:0];
        if (wr_en && wr_addr == OFS_DW1) dw1 <= wr_data;
        if (wr_en && wr_addr == OFS_DW2) dw2 <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; vlan_q <= 1'b0; clr_q <= 1'b0; clr_cnt <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wr_data[31];
        vlan_q <= wr_data[2];
      end
      if (clr_q) begin
        clr_cnt <= clr_cnt + 1'b1;
        if (clr_cnt == IW'(DEPTH-1)) clr_q <= 1'b0;
      end else if (wr_ctrl && wr_data[30]) begin
        clr_q   <= 1'b1;
        clr_cnt <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPORTS; p++) pst[p] <= 2'd0;
    end else begin
      for (int p = 0; p < NPORTS; p++)
        if (wr_en && wr_addr == AW'(OFS_PORT + 4*p)) pst[p] <= wr_data[1:0];
    end
  end

  // slot search
  logic [IW-1:0] scan, free_idx, age_idx;
  logic          free_hit, age_hit;
  logic [47:0]   mac_q;

  wire is_addr  = tbl[scan][60];
  wire is_free  = tbl[scan][61:60] == 2'd0;
  wire is_match = is_addr && tbl[scan][47:0] == mac_q;
  wire is_age   = is_addr && !tbl[scan][40] && tbl[scan][62];
  wire last     = scan == IW'(DEPTH-1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srch_busy <= 1'b0; srch_done <= 1'b0; srch_found <= 1'b0; srch_idx <= '0;
      scan <= '0; free_idx <= '0; age_idx <= '0; free_hit <= 1'b0; age_hit <= 1'b0;
      mac_q <= '0;
    end else begin
      srch_done <= 1'b0;
      if (!srch_busy) begin
        if (srch_start && !clr_q) begin
          srch_busy <= 1'b1; scan <= '0; mac_q <= srch_mac;
          free_hit <= 1'b0; age_hit <= 1'b0; srch_found <= 1'b0;
        end
      end else if (is_match) begin
        srch_busy <= 1'b0; srch_done <= 1'b1; srch_found <= 1'b1; srch_idx <= scan;
      end else begin
        if (is_free && !free_hit) begin free_hit <= 1'b1; free_idx <= scan; end
        if (is_age && !age_hit) begin age_hit <= 1'b1; age_idx <= scan; end
        if (last) begin
          srch_busy <= 1'b0;
          srch_done <= 1'b1;
          if (free_hit || is_free) begin
            srch_found <= 1'b1; srch_idx <= free_hit ? free_idx : scan;
          end else if (age_hit || is_age) begin
            srch_found <= 1'b1; srch_idx <= age_hit ? age_idx : scan;
          end else begin
            srch_found <= 1'b0;
          end
        end else begin
          scan <= scan + 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFS_CTRL: rd_data = {en_q, clr_q, 27'd0, vlan_q, 2'd0};
      OFS_TCTL: rd_data = {{(32-IW){1'b0}}, tidx};
      OFS_DW0:  rd_data = {28'd0, dw0};
      OFS_DW1:  rd_data = dw1;
      OFS_DW2:  rd_data = dw2;
      default:  rd_data = '0;
    endcase
    for (int p = 0; p < NPORTS; p++)
      if (rd_addr == AW'(OFS_PORT + 4*p)) rd_data = {30'd0, pst[p]};
  end

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    srch_done |-> !srch_busy);
  assert_start_accepted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_start && !srch_busy && !clr_q) |=> srch_busy);
  assert_done_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    srch_done |=> !srch_done);
  assert_entry_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr |=> tbl[$past(widx)] == $past({dw0, dw1, dw2}));
  assert_clear_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && clr_cnt == IW'(DEPTH-1)) |=> !clr_q);
  assert_result_not_vlan_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_done && srch_found) |-> tbl[srch_idx][61:60] != 2'd2);
endmodule

// File: tb/addr_lookup_table_tb.sv
module addr_lookup_table_tb;
  localparam int DEPTH = 64;
  localparam int IW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [7:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic srch_start = 0;
  logic [47:0] srch_mac = 0;
  logic srch_busy, srch_done, srch_found;
  logic [IW-1:0] srch_idx;

  always #2 clk = ~clk;

  addr_lookup_table #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .srch_start(srch_start), .srch_mac(srch_mac),
    .srch_busy(srch_busy), .srch_done(srch_done), .srch_found(srch_found), .srch_idx(srch_idx));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  bit exp_f[$];
  int exp_i[$];
  string exp_t[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  function automatic logic [67:0] mk(input logic [1:0] typ, input logic [47:0] mac, input logic [1:0] ut);
    mk = '0; mk[47:0] = mac; mk[61:60] = typ; mk[63:62] = ut;
  endfunction

  function automatic logic [47:0] mac_of(input int i);
    mac_of = 48'h02_00_00_00_10_00 + 48'(i);
  endfunction

  task automatic put(input int idx, input logic [67:0] e);
    wr(8'h34, {28'd0, e[67:64]});
    wr(8'h38, e[63:32]);
    wr(8'h3C, e[31:0]);
    wr(8'h20, 32'h8000_0000 | 32'(idx));
  endtask

  // driver: pushes the expected result, runs the search, checks busy length
  task automatic srch(input logic [47:0] mac, input bit ef, input int ei, input string tag,
                      input int ebusy, input bit poke);
    int bcnt = 0, guard = 0;
    exp_f.push_back(ef); exp_i.push_back(ei); exp_t.push_back(tag);
    @(negedge clk); srch_start = 1; srch_mac = mac;
    @(negedge clk); srch_start = 0;
    while (!srch_done && guard < 4*DEPTH) begin
      if (srch_busy) bcnt++;
      srch_start = poke && bcnt == 2;
      if (srch_start) srch_mac = ~mac;
      @(negedge clk);
      guard++;
    end
    srch_start = 0;
    if (ebusy >= 0) chk({tag, " busy cycles R10"}, 32'(bcnt), 32'(ebusy));
  endtask

  // monitor: pops and compares on each done pulse
  always @(negedge clk) begin
    if (rst_n && srch_done) begin
      if (exp_f.size() == 0) begin
        chk("unexpected done R10", 32'd1, 32'd0);
      end else begin
        automatic bit ef = exp_f.pop_front();
        automatic int ei = exp_i.pop_front();
        automatic string t = exp_t.pop_front();
        chk({t, " found"}, 32'(srch_found), 32'(ef));
        if (ef) chk({t, " index"}, 32'(srch_idx), 32'(ei));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(8'h08, d); chk("R1 ctrl reset", d, 0);
    rd(8'h40, d); chk("R1 port0 reset", d, 0);
    rd(8'h48, d); chk("R1 port2 reset", d, 0);
    chk("R1 busy/done reset", {30'd0, srch_busy, srch_done}, 0);

    put(5, mk(1, mac_of(5), 3));
    wr(8'h08, 32'h4000_0000);
    rd(8'h08, d); chk("R5 clear in progress", d[30], 1);
    repeat (DEPTH + 2) @(negedge clk);
    rd(8'h08, d); chk("R5 clear finished", d[30], 0);
    wr(8'h20, 32'd5);
    rd(8'h38, d); chk("R5 entry cleared hi", d, 0);
    rd(8'h3C, d); chk("R5 entry cleared lo", d, 0);

    wr(8'h08, 32'h8000_0004);
    rd(8'h08, d); chk("R4 enable/vlan readback", d, 32'h8000_0004);

    put(7, 68'hA_1234_5678_9ABC_DEF0);
    wr(8'h34, 32'h5); wr(8'h38, 32'hDEAD_BEEF); wr(8'h3C, 32'h0);
    wr(8'h20, 32'd7);
    rd(8'h34, d); chk("R2 R3 word0 top bits", d, 32'hA);
    rd(8'h38, d); chk("R2 R3 word1 mid bits", d, 32'h1234_5678);
    rd(8'h3C, d); chk("R2 R3 word2 low bits", d, 32'h9ABC_DEF0);
    put(7, '0);

    srch(mac_of(1), 1, 0, "R7 empty table free", 64, 0);
    put(0, mk(2, mac_of(1), 0));
    put(1, mk(1, mac_of(1), 0));
    put(9, mk(3, mac_of(9), 0));
    srch(mac_of(1), 1, 1, "R6 R12 match skips vlan", 2, 0);
    srch(mac_of(9), 1, 9, "R6 match beats free", 10, 0);
    srch(mac_of(5), 1, 2, "R7 lowest free", 64, 0);

    for (int i = 0; i < DEPTH; i++) put(i, mk(1, mac_of(i), 0));
    put(10, mk(2, mac_of(100), 3));
    put(20, mk(1, 48'h01_00_5E_00_00_20, 3));
    put(30, mk(1, mac_of(30), 2));
    put(40, mk(3, mac_of(40), 1));
    put(50, mk(1, mac_of(50), 3));
    srch(mac_of(100), 1, 40, "R8 R12 first ageable", 64, 0);
    put(40, mk(3, mac_of(40), 0));
    srch(mac_of(100), 1, 50, "R8 touched ageable", 64, 0);
    put(50, mk(1, mac_of(50), 0));
    srch(mac_of(100), 0, 0, "R9 no slot", 64, 0);
    srch(mac_of(60), 1, 60, "R10 start ignored while busy", 61, 1);

    wr(8'h48, 32'd3);
    wr(8'h44, 32'hFFFF_FFFE);
    rd(8'h48, d); chk("R11 port2 state", d, 3);
    rd(8'h44, d); chk("R11 port1 two bits only", d, 2);
    rd(8'h40, d); chk("R11 port0 untouched", d, 0);

    repeat (4) @(negedge clk);
    chk("R10 all searches completed", 32'(exp_f.size()), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule